// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block is the control state machine of a two-wire (I2C) hot-insertion buffer. When a card is plugged into a live backplane, it decides the moment at which the card's bus segment may be joined to the backplane segment. It takes raw samples of SDA and SCL from both segments and synchronizes them itself. An enable input tells it that start-up has finished. It drives three outputs: a connect command for the external pass switches, an enable for the external pre-charge bias, and a ready flag.

After enable goes high, the controller enters the waiting mode and turns on pre-charge. It then watches the card segment for one of two signs that the bus is quiet. The first is both lines held high for a programmable number of cycles. The second is a STOP condition. The backplane lines must also both be high before the link is made. Once joined, the two segments stay connected until enable falls or reset is applied. Clock stretching and arbitration then pass through the switches untouched.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: Each of the four line inputs passes through a two-flop synchronizer that resets to high. A change on an input can first influence the control logic at the third rising clock edge after it is applied, so a newly qualifying change shows on the outputs after exactly three edges.
- R2: While reset is asserted, and after reset until enable is seen high, the controller is in start-up mode with connect_o, precharge_o and ready_o all low.
- R3: In start-up mode with enable_i high, the next rising edge moves the controller to the waiting mode. In the waiting mode precharge_o is 1 while connect_o and ready_o are 0.
- R4: A STOP is a rising edge of synchronized card SDA while synchronized card SCL is high. In the waiting mode, a STOP with both backplane lines high connects at the following edge.
- R5: The idle timer counts edges at which both synchronized card lines are high, outside start-up. Any low on either line clears it, and it saturates at IDLE_CYCLES. Its expiry qualifies the link, so from start-up with every line steady high, connect_o rises at the (IDLE_CYCLES+2)-th edge after enable is applied.
- R6: No connection is made unless both synchronized backplane lines are high, whatever the card segment shows.
- R7: A STOP or timer expiry seen in the waiting mode while the backplane is not idle is remembered. The link then forms as soon as both backplane lines are high, even if the card-side qualifier has gone away.
- R8: On connection the controller enters the active mode. There, connect_o and ready_o are 1 and precharge_o is 0, all changing at the same edge.
- R9: In the active mode, activity on any line is ignored and the link stays made while enable_i is high.
- R10: enable_i low at a rising edge returns the controller from any mode to start-up. All outputs are then low and any remembered qualifier is dropped.
- R11: STOP conditions and idle time seen in start-up mode are not remembered and do not qualify a later connection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Start-up finished; low forces start-up mode |
| card_sda_i | input | 1 | SDA sample from the card segment (unsynchronized) |
| card_scl_i | input | 1 | SCL sample from the card segment (unsynchronized) |
| bp_sda_i | input | 1 | SDA sample from the backplane segment (unsynchronized) |
| bp_scl_i | input | 1 | SCL sample from the backplane segment (unsynchronized) |
| connect_o | output | 1 | Registered command closing the pass switches |
| precharge_o | output | 1 | Registered enable of the pre-charge bias |
| ready_o | output | 1 | Registered flag: segments are joined |

## Verification
The checker watches several rules on every cycle. Pre-charge and connect never overlap, and ready tracks connect. A rising connect is always preceded by the waiting mode, by a high backplane and by a live qualifier. Connect only falls after enable was low, a detected STOP always coincides with a high card SCL, and the idle count never passes its limit. Exact latencies can only be shown by the bench's scenarios: the (IDLE_CYCLES+2)-edge idle path, the three-edge reaction to a backplane release or a STOP, a qualifier held across a busy backplane, and STOPs discarded during start-up. A cycle-level reference model in the bench covers random line activity and enable drops.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  typedef enum logic [1:0] {
    LINK_START  = 2'd0,
    LINK_WAIT   = 2'd1,
    LINK_ACTIVE = 2'd2
  } link_state_e;
endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
  parameter int          W         = 2,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RESET_VAL;
      stage2 <= RESET_VAL;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/hsl_stop_detect.sv
module hsl_stop_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  output logic stop_o
);
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev <= 1'b1;
    else        sda_prev <= sda_s_i;
  end

  // rising data line while the clock line is high
  assign stop_o = arm_i & scl_s_i & sda_s_i & ~sda_prev;
endmodule

// File: rtl/hsl_idle_timer.sv
module hsl_idle_timer #(
  parameter int IDLE_CYCLES = 1000,
  localparam int CW = $clog2(IDLE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          sda_s_i,
  input  logic          scl_s_i,
  output logic          expired_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic run);
    if (!run)           return '0;
    else if (cur == LIMIT) return LIMIT;
    else                return cur + 1'b1;
  endfunction

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= next_count(count_q, arm_i & sda_s_i & scl_s_i);
  end

  assign expired_o = (count_q == LIMIT);
  assign count_o   = count_q;
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl #(
  parameter int IDLE_CYCLES = 1000,
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic card_sda_i,
  input  logic card_scl_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  output logic connect_o,
  output logic precharge_o,
  output logic ready_o
);
  import hsl_pkg::*;

  link_state_e state_q, state_d;
  logic        pending_q, pending_d;
  logic [1:0]  card_s;   // {sda, scl}
  logic [1:0]  bp_s;     // {sda, scl}
  logic        detect_arm;
  logic        stop_evt;
  logic        idle_expired;
  logic [CNT_W-1:0] idle_count;
  logic        bp_high;
  logic        qual_any;

  hsl_sync #(.W(2), .RESET_VAL(2'b11)) u_sync_card (
    .clk(clk), .rst_n(rst_n), .d_i({card_sda_i, card_scl_i}), .q_o(card_s)
  );

  hsl_sync #(.W(2), .RESET_VAL(2'b11)) u_sync_bp (
    .clk(clk), .rst_n(rst_n), .d_i({bp_sda_i, bp_scl_i}), .q_o(bp_s)
  );

  assign detect_arm = (state_q != LINK_START);

  hsl_stop_detect u_stop (
    .clk(clk), .rst_n(rst_n), .arm_i(detect_arm),
    .sda_s_i(card_s[1]), .scl_s_i(card_s[0]), .stop_o(stop_evt)
  );

  hsl_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm_i(detect_arm),
    .sda_s_i(card_s[1]), .scl_s_i(card_s[0]),
    .expired_o(idle_expired), .count_o(idle_count)
  );

  assign bp_high  = &bp_s;
  assign qual_any = pending_q | stop_evt | idle_expired;

  always_comb begin
    state_d = state_q;
    if (!enable_i) begin
      state_d = LINK_START;
    end else begin
      unique case (state_q)
        LINK_START:  state_d = LINK_WAIT;
        LINK_WAIT:   if (bp_high && qual_any) state_d = LINK_ACTIVE;
        LINK_ACTIVE: state_d = LINK_ACTIVE;
        default:     state_d = LINK_START;
      endcase
    end
  end

  always_comb begin
    pending_d = 1'b0;
    if (state_d == LINK_WAIT && state_q == LINK_WAIT) pending_d = qual_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LINK_START;
      pending_q   <= 1'b0;
      connect_o   <= 1'b0;
      precharge_o <= 1'b0;
      ready_o     <= 1'b0;
    end else begin
      state_q     <= state_d;
      pending_q   <= pending_d;
      connect_o   <= (state_d == LINK_ACTIVE);
      precharge_o <= (state_d == LINK_WAIT);
      ready_o     <= (state_d == LINK_ACTIVE);
    end
  end
endmodule

// File: rtl/hsl_checker.sv
module hsl_checker #(
  parameter int IDLE_CYCLES = 1000,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable_i,
  input logic          connect_o,
  input logic          precharge_o,
  input logic          ready_o,
  input logic          bp_high,
  input logic          qual_any,
  input logic          stop_evt,
  input logic          card_scl_s,
  input logic [CW-1:0] idle_count
);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge_o && connect_o));

  assert_ready_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o == connect_o);

  assert_connect_from_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect_o) |-> $past(precharge_o));

  assert_connect_needs_bp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect_o) |-> $past(bp_high) && $past(qual_any));

  assert_hold_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connect_o) |-> $past(!enable_i));

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !connect_o && !precharge_o && !ready_o);

  assert_stop_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> card_scl_s);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_count <= CW'(IDLE_CYCLES));
endmodule

bind hotswap_link_ctrl hsl_checker #(.IDLE_CYCLES(IDLE_CYCLES), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
  .connect_o(connect_o), .precharge_o(precharge_o), .ready_o(ready_o),
  .bp_high(bp_high), .qual_any(qual_any), .stop_evt(stop_evt),
  .card_scl_s(card_s[0]), .idle_count(idle_count)
);

// File: tb/hotswap_link_ctrl_test.sv
module hotswap_link_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic c_sda = 1'b1, c_scl = 1'b1, b_sda = 1'b1, b_scl = 1'b1;
  logic connect, precharge, ready;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hotswap_link_ctrl #(.IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(en),
    .card_sda_i(c_sda), .card_scl_i(c_scl), .bp_sda_i(b_sda), .bp_scl_i(b_scl),
    .connect_o(connect), .precharge_o(precharge), .ready_o(ready)
  );

  // reference model, written from the requirements
  logic [1:0] m_c1, m_c2, m_b1, m_b2;
  logic       m_prev, m_pend;
  int         m_cnt, m_st;  // 0 start, 1 waiting, 2 active

  function automatic int bump(int c, bit run);
    if (!run) return 0;
    return (c + 1 > IDLE) ? IDLE : c + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c1 <= 2'b11; m_c2 <= 2'b11; m_b1 <= 2'b11; m_b2 <= 2'b11;
      m_prev <= 1'b1; m_pend <= 1'b0; m_cnt <= 0; m_st <= 0;
    end else begin
      bit armed, stp, expd, qual;
      int nxt;
      armed = (m_st != 0);
      stp   = armed && m_c2[1] && !m_prev && m_c2[0];
      expd  = (m_cnt == IDLE);
      qual  = m_pend || stp || expd;
      if (!en)            nxt = 0;
      else if (m_st == 0) nxt = 1;
      else if (m_st == 1) nxt = (m_b2 == 2'b11 && qual) ? 2 : 1;
      else                nxt = 2;
      m_pend <= (nxt == 1 && m_st == 1) ? qual : 1'b0;
      m_cnt  <= bump(m_cnt, armed && m_c2 == 2'b11);
      m_prev <= m_c2[1];
      m_c1 <= {c_sda, c_scl}; m_c2 <= m_c1;
      m_b1 <= {b_sda, b_scl}; m_b2 <= m_b1;
      m_st <= nxt;
    end
  end

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("R3 precharge vs model", precharge, m_st == 1);
    check("R8 connect vs model",   connect,   m_st == 2);
    check("R8 ready vs model",     ready,     m_st == 2);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0042));
    // R2: reset state
    repeat (3) @(negedge clk);
    check("R2 connect in reset", connect, 1'b0);
    check("R2 precharge in reset", precharge, 1'b0);
    check("R2 ready in reset", ready, 1'b0);
    rst_n = 1'b1;
    steps(3);
    check("R2 precharge before enable", precharge, 1'b0);

    // R5: idle path latency with every line steady high
    en = 1'b1;
    n = 0;
    while (!connect && n < 100) begin step(); n++; end
    check("R5 connect after IDLE+2 edges", n == IDLE + 2, 1'b1);
    check("R8 precharge off when active", precharge, 1'b0);

    // R9: activity ignored while active
    for (int i = 0; i < 30; i++) begin
      c_sda = 1'($urandom); c_scl = 1'($urandom);
      b_sda = 1'($urandom); b_scl = 1'($urandom);
      step();
      check("R9 link held", connect, 1'b1);
    end

    // R10: enable drop returns to start-up
    c_sda = 1; c_scl = 1; b_sda = 1; b_scl = 1;
    en = 1'b0;
    step();
    check("R10 connect low", connect, 1'b0);
    check("R10 precharge low", precharge, 1'b0);
    check("R10 ready low", ready, 1'b0);
    steps(3);

    // R6 / R1: card idle but backplane busy, then released
    b_sda = 0; b_scl = 0;
    en = 1'b1;
    steps(IDLE + 6);
    check("R6 no connect while backplane low", connect, 1'b0);
    check("R3 precharge while waiting", precharge, 1'b1);
    b_sda = 1; b_scl = 1;
    steps(2);
    check("R1 not yet after two edges", connect, 1'b0);
    step();
    check("R1 connect at third edge", connect, 1'b1);

    // R11: STOP during start-up is discarded
    en = 1'b0; step();
    c_sda = 0; steps(3); c_sda = 1; steps(3);
    c_scl = 0; steps(3);
    en = 1'b1;
    steps(10);
    check("R11 start-up STOP not remembered", connect, 1'b0);

    // R4: STOP in waiting mode connects
    c_sda = 0; steps(3);
    c_scl = 1; steps(3);
    c_sda = 1;
    steps(2);
    check("R4 not before STOP is seen", connect, 1'b0);
    step();
    check("R4 connect after STOP", connect, 1'b1);

    // R7: STOP held pending across a busy backplane
    en = 1'b0; step();
    b_sda = 0; b_scl = 0; c_sda = 0; c_scl = 1;
    en = 1'b1; steps(4);
    c_sda = 1; steps(4);
    c_scl = 0; steps(6);
    check("R7 waiting while backplane busy", connect, 1'b0);
    b_sda = 1; b_scl = 1;
    steps(3);
    check("R7 pending STOP connects", connect, 1'b1);

    // random traffic against the model (R1..R11)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0) c_sda = 1'($urandom);
      if ($urandom % 4 == 0) c_scl = 1'($urandom);
      if ($urandom % 6 == 0) b_sda = 1'($urandom);
      if ($urandom % 6 == 0) b_scl = 1'($urandom);
      if ($urandom % 16 == 0) begin c_sda = 1; c_scl = 1; b_sda = 1; b_scl = 1; end
      en = ($urandom % 80) != 0;
      step();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule